// File: doc/BRIEF.md
# Reloadable Periodic Tick Timer

This block is a system tick timer built on a 24-bit down-counter. Software programs a reload value and a control word through a small register port. When enabled, the counter steps down once per tick. Each tick is either every core clock cycle or one rising edge of an external reference signal, which is synchronized into the core clock domain. When the count steps from one to zero, the block raises a tick event. That event sets a sticky count-flag and, if interrupts are enabled, produces a one-cycle interrupt request.

In periodic operation the zero count is followed by a reload, so the timer repeats with a period of reload-plus-one ticks. In one-shot operation the counter reaches zero once and then stays there until software restarts it by writing the current-value register. The current count can be read at any time to measure elapsed time. Clearing the enable bit freezes the count where it is.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the reload value and the current count all read 0, and `irq` and `count_flag` are low.
- R2: Registers sit at word address 0 (control), 1 (reload, bits 23:0) and 2 (current count). The control word has these fields: bit 0 enable, bit 1 interrupt enable, bit 2 source select (1 = core clock, 0 = external reference) and bit 3 one-shot. The count-flag reads back in bit 16.
- R3: In periodic mode with reload N > 0, the count goes N, N-1, ..., 1, 0 and then reloads N. Tick events therefore recur every N+1 ticks.
- R4: A tick event drives `irq` high for exactly one cycle, in the cycle where the count first reads 0. This happens only when interrupt enable is set.
- R5: With reload 0, the counter stays at 0 and never raises a tick event, the flag or `irq`.
- R6: In one-shot mode the counter produces one tick event, then holds at 0 on later ticks.
- R7: With source select 0, each rising edge of `ext_ref` yields exactly one tick after a two-flop synchronizer, however long the level is held. Core clock cycles alone do not move the count.
- R8: The current count reads back live and shows the decrementing value.
- R9: Any write to the current-value register clears the count, the count-flag and the one-shot stop. The next tick then loads the reload value and raises no tick event.
- R10: The count-flag sets on the 1-to-0 step and clears on a read of the control register. A set in the same cycle as the read wins.
- R11: Clearing enable freezes the count at its present value, with no reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of the control word clears the flag) |
| addr | input | 2 | Register word address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data, combinational from `addr` |
| ext_ref | input | 1 | External reference tick source, asynchronous |
| irq | output | 1 | One-cycle interrupt request |
| count_flag | output | 1 | Sticky count-flag |

## Verification
The assertions check the following on every cycle:
- each enabled tick above one steps the count down by exactly one;
- a disabled counter holds still;
- a zero reload keeps the count at zero;
- `irq` appears only together with a zero count and only for one cycle;
- a tick event always leaves the flag set;
- the synchronized reference pulse never lasts two cycles.

Only the bench scenarios can show the following:
- the N+1 period measured between interrupts;
- the one-shot stop and its restart;
- the flag clearing on a control read;
- the count of ticks taken from a train of reference edges;
- the exact value frozen after a known number of ticks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned TT_ADDR_W = 2;

  localparam logic [TT_ADDR_W-1:0] TT_A_CTRL   = 2'd0;
  localparam logic [TT_ADDR_W-1:0] TT_A_RELOAD = 2'd1;
  localparam logic [TT_ADDR_W-1:0] TT_A_CUR    = 2'd2;

  localparam int unsigned TT_FLAG_BIT = 16;

  // Packed in bit order: one_shot=3, core_src=2, irq_en=1, run=0
  typedef struct packed {
    logic one_shot;
    logic core_src;
    logic irq_en;
    logic run;
  } tt_ctrl_t;

  // Count value after one enabled tick
  function automatic logic [23:0] tt_next_count(input logic [23:0] cnt,
                                                input logic [23:0] reload,
                                                input logic        hold_zero);
    if (cnt == '0) return hold_zero ? 24'd0 : reload;
    return cnt - 24'd1;
  endfunction

endpackage

// File: rtl/tt_ref_sync.sv
module tt_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ref,
  output logic ref_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ext_ref;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign ref_pulse = sync_q[STAGES-1] & ~prev_q;

  // R7: a held reference level gives a single tick
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [TT_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]     wdata,
  input  logic [CNT_W-1:0]     count,
  input  logic                 wrap_evt,
  output tt_ctrl_t             ctrl,
  output logic [CNT_W-1:0]     reload,
  output logic                 cur_wr,
  output logic                 flag,
  output logic [CNT_W-1:0]     rdata
);
  localparam int unsigned CW = $bits(tt_ctrl_t);

  logic ctrl_wr, reload_wr, ctrl_rd;

  assign ctrl_wr   = wr_en && addr == TT_A_CTRL;
  assign reload_wr = wr_en && addr == TT_A_RELOAD;
  assign cur_wr    = wr_en && addr == TT_A_CUR;
  assign ctrl_rd   = rd_en && addr == TT_A_CTRL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      flag   <= 1'b0;
    end else begin
      if (ctrl_wr)   ctrl   <= tt_ctrl_t'(wdata[CW-1:0]);
      if (reload_wr) reload <= wdata;
      if (wrap_evt)                flag <= 1'b1;
      else if (ctrl_rd || cur_wr)  flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      TT_A_CTRL: begin
        rdata[CW-1:0]       = ctrl;
        rdata[TT_FLAG_BIT]  = flag;
      end
      TT_A_RELOAD: rdata = reload;
      TT_A_CUR:    rdata = count;
      default:     rdata = '0;
    endcase
  end

  // R10: a tick event always leaves the flag set
  p_flag_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  tt_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] reload,
  input  logic             cur_wr,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             irq
);
  logic active;
  logic stopped;

  assign active   = tick_en && ctrl.run;
  assign wrap_evt = active && !cur_wr && count == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      stopped <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= wrap_evt && ctrl.irq_en;
      if (cur_wr) begin
        count   <= '0;
        stopped <= 1'b0;
      end else if (active) begin
        count <= tt_next_count(count, reload, ctrl.one_shot && stopped);
        if (count == CNT_W'(1) && ctrl.one_shot) stopped <= 1'b1;
      end
    end
  end

  // R8: an enabled tick above one steps the count down by one
  p_step_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cur_wr && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));
  // R11: a disabled counter holds its value
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !cur_wr) |=> $stable(count));
  // R5: a zero reload keeps the count at zero
  p_zero_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload == '0) |=> count == '0);
  // R4: irq only with a zero count, one cycle wide
  p_irq_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count == '0);
  p_irq_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [TT_ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]     wdata,
  output logic [CNT_W-1:0]     rdata,
  input  logic                 ext_ref,
  output logic                 irq,
  output logic                 count_flag
);
  tt_ctrl_t         ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             cur_wr, wrap_evt, ref_pulse, tick_en;

  tt_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_ref(ext_ref), .ref_pulse(ref_pulse));

  assign tick_en = ctrl.core_src ? 1'b1 : ref_pulse;

  tt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .wrap_evt(wrap_evt), .ctrl(ctrl),
    .reload(reload), .cur_wr(cur_wr), .flag(count_flag), .rdata(rdata));

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl(ctrl),
    .reload(reload), .cur_wr(cur_wr), .count(count),
    .wrap_evt(wrap_evt), .irq(irq));

  // R9: a current-value write forces the count to zero
  p_clear_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> (count == '0 && !count_flag));
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        ext_ref = 1'b0;
  logic        irq, count_flag;

  int checks = 0, failures = 0;
  int cycle = 0;
  int irq_times[$];
  bit finished = 0;

  typedef struct { logic [23:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  localparam logic [23:0] FLAG = 24'h010000;

  tick_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ext_ref(ext_ref),
    .irq(irq), .count_flag(count_flag));

  always #4 clk = ~clk;

  always @(posedge clk) cycle <= cycle + 1;

  // Monitor: pops expected reads, records irq pulses
  always @(negedge clk) begin
    if (rd_en && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
    if (irq) irq_times.push_back(cycle);
  end

  task automatic check_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [23:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [23:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic setup(input logic [23:0] rl, input logic [23:0] ctl);
    bus_write(2'd0, 24'd0);
    bus_write(2'd1, rl);
    bus_write(2'd2, 24'd0);
    irq_times.delete();
    bus_write(2'd0, ctl);
  endtask

  task automatic ref_pulse(input int hi, input int lo);
    ext_ref = 1'b1; wait_cycles(hi);
    ext_ref = 1'b0; wait_cycles(lo);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(1);

    // R1 reset state
    bus_read(2'd0, 24'h0, "R1 ctrl");
    bus_read(2'd1, 24'h0, "R1 reload");
    bus_read(2'd2, 24'h0, "R1 count");
    check_eq(int'(irq) + int'(count_flag), 0, "R1 irq/flag");

    // R2, R3, R4 periodic reload 5: period 6
    bus_write(2'd1, 24'hABCDEF);
    bus_read(2'd1, 24'hABCDEF, "R2 reload readback");
    setup(24'd5, 24'h7);
    wait_cycles(30);
    check_eq(irq_times.size() >= 3 ? irq_times[1] - irq_times[0] : -1, 6, "R3 period 1");
    check_eq(irq_times.size() >= 3 ? irq_times[2] - irq_times[1] : -1, 6, "R4 one-cycle irq, period 2");
    bus_read(2'd0, 24'h7 | FLAG, "R2 ctrl with flag");

    // R11, R8 freeze after known ticks
    bus_write(2'd0, 24'd0);
    bus_write(2'd1, 24'd1000);
    bus_write(2'd2, 24'd0);
    bus_write(2'd0, 24'h5);
    wait_cycles(10);
    bus_write(2'd0, 24'h4);
    bus_read(2'd2, 24'd990, "R8 live count");
    wait_cycles(20);
    bus_read(2'd2, 24'd990, "R11 frozen count");

    // R5 zero reload
    setup(24'd0, 24'h7);
    wait_cycles(40);
    check_eq(irq_times.size(), 0, "R5 no irq");
    bus_read(2'd2, 24'd0, "R5 count stays 0");
    bus_read(2'd0, 24'h7, "R5 no flag");

    // R4 irq disabled: flag sets, no irq
    setup(24'd2, 24'h5);
    wait_cycles(20);
    check_eq(irq_times.size(), 0, "R4 irq gated by enable");
    bus_read(2'd0, 24'h5 | FLAG, "R10 flag without irq");

    // R6, R10, R9 one-shot
    setup(24'd3, 24'hF);
    wait_cycles(20);
    check_eq(irq_times.size(), 1, "R6 single event");
    bus_read(2'd2, 24'd0, "R6 held at zero");
    bus_read(2'd0, 24'hF | FLAG, "R10 flag set");
    bus_read(2'd0, 24'hF, "R10 flag cleared by read");
    bus_write(2'd2, 24'd0);
    wait_cycles(2);
    check_eq(irq_times.size(), 1, "R9 load after clear raises no irq");
    wait_cycles(20);
    check_eq(irq_times.size(), 2, "R9 one-shot restarted");
    bus_write(2'd2, 24'd0);
    bus_read(2'd0, 24'hF, "R9 write clears flag");

    // R7 external reference
    setup(24'd100, 24'h1);
    wait_cycles(20);
    bus_read(2'd2, 24'd0, "R7 no core ticks");
    ref_pulse(4, 4);
    ref_pulse(20, 4);
    ref_pulse(4, 4);
    ref_pulse(4, 4);
    ref_pulse(4, 4);
    wait_cycles(6);
    bus_read(2'd2, 24'd96, "R7 one tick per edge");
    bus_write(2'd0, 24'd0);

    wait_cycles(4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule